// File: doc/BRIEF.md
# Interleaved DRAM Bank Address Mapper

This block translates a processor long-word address into a physical DRAM bank and a long-word offset inside that bank. The memory has ten banks, each 32 bits wide. The banks are grouped into five fixed pairs. Each pair works in one of two modes. In interleaved mode, consecutive long words alternate between the two banks. In linear mode, the first bank of the pair is used completely before the second one. Both modes can be in use at the same time in one address map.

At boot, software presents a size code for every bank and pulses a configure strobe. In that single cycle the block does three things. It decides the mode of each pair: a pair interleaves only when both of its banks are installed and have equal size. It stacks the pairs one after another in address space. It latches the mode bits, pair base addresses and bank lengths. After that, every address is mapped against the latched configuration, and the result is registered after one clock. An address beyond the end of installed memory reports a miss and selects no bank.

Top module: `ilv_bank_mapper`

## Requirements
- R1: After reset, and until the first configure strobe, every pair is linear and every address reports a miss (`map_hit`=0, `map_bank`=0, `map_off`=0, `map_ilv`=0).
- R2: Bank b takes its size code from `bank_size[2b+1:2b]`: 0 means empty, 1 means small (2^20 long words), 2 means large (2^22 long words), and 3 is treated as empty.
- R3: The pairs, listed as (first, second) bank, are: pair 0 = (0,1), pair 1 = (2,4), pair 2 = (3,5), pair 3 = (6,8), pair 4 = (7,9).
- R4: A pair is interleaved only when both of its banks are non-empty and their sizes are equal. Otherwise the pair is linear.
- R5: In an interleaved pair, for relative long-word offset r inside the pair: an even r selects the first bank and an odd r selects the second bank, the in-bank offset is r/2, and `map_ilv`=1.
- R6: In a linear pair, offsets below the first bank's length go to the first bank unchanged. The remaining offsets go to the second bank, minus the first bank's length. An empty bank takes no space, and `map_ilv`=0.
- R7: Pairs are stacked in ascending order of pair number. A pair's base is the sum of the lengths of all lower-numbered pairs, and a pair's length is the sum of the lengths of its two banks.
- R8: An address at or above the total installed length reports a miss, with `map_bank`, `map_off` and `map_ilv` all zero.
- R9: Changes on `bank_size` have no effect unless `cfg_strobe` is high. The configuration latched by the strobe holds until the next strobe or reset.
- R10: Outputs reflect the address sampled at the previous rising clock edge, mapped with the configuration in effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_strobe | input | 1 | Latch configuration derived from `bank_size` |
| bank_size | input | 20 | Two-bit size code per bank |
| addr | input | ADDR_W (26) | Long-word address |
| map_hit | output | 1 | Address falls in installed memory |
| map_bank | output | 4 | Selected bank index |
| map_off | output | LARGE_LOG2 (22) | Long-word offset inside the bank |
| map_ilv | output | 1 | Mapping used interleaved mode |

## Verification
The main table uses a mixed configuration. It has two equal-small banks, two equal-large banks, a pair with only one bank installed, a pair with mismatched sizes, and an empty pair. The table probes the first, last, even and odd addresses of each pair. Those probes tell apart bank alternation, linear fill with its switch point, and the stacking of each base. A second configuration has the first bank of a pair missing and a reserved code standing in for an empty bank. It shows that present banks of a broken pair still map linearly from the pair's base. Separate directed steps cover the following:
- `bank_size` changes while the strobe is low, which must leave the mapping unchanged;
- the one-cycle output latency;
- a reset in mid-run, which must return the block to all-miss.

// File: rtl/ilv_map_pkg.sv
package ilv_map_pkg;

    localparam int NUM_BANKS  = 10;
    localparam int NUM_PAIRS  = 5;
    localparam int BANK_IDX_W = 4;
    localparam int SIZE_W     = 2;

    typedef enum logic [SIZE_W-1:0] {
        SZ_NONE  = 2'd0,
        SZ_SMALL = 2'd1,
        SZ_LARGE = 2'd2,
        SZ_RSVD  = 2'd3
    } size_code_e;

    // Pair 0 is the on-board bank pair. Each expansion pair joins a bank
    // with the bank of the same side in the neighbouring slot.
    function automatic int pair_first_bank(input int p);
        return (p == 0) ? 0 : 2 + 4 * ((p - 1) / 2) + ((p - 1) % 2);
    endfunction

    function automatic int pair_second_bank(input int p);
        return (p == 0) ? 1 : pair_first_bank(p) + 2;
    endfunction

endpackage

// File: rtl/ilv_cfg_calc.sv
module ilv_cfg_calc
    import ilv_map_pkg::*;
#(
    parameter int ADDR_W     = 26,
    parameter int SMALL_LOG2 = 20,
    parameter int LARGE_LOG2 = 22
) (
    input  logic [NUM_BANKS*SIZE_W-1:0]       bank_size,
    output logic [NUM_PAIRS-1:0]              pair_ilv,
    output logic [NUM_PAIRS-1:0][ADDR_W-1:0]  pair_base,
    output logic [NUM_PAIRS-1:0][ADDR_W-1:0]  len_a,
    output logic [NUM_PAIRS-1:0][ADDR_W-1:0]  len_b
);

    function automatic logic [ADDR_W-1:0] code_len(input logic [SIZE_W-1:0] c);
        case (size_code_e'(c))
            SZ_SMALL: code_len = ADDR_W'(1) << SMALL_LOG2;
            SZ_LARGE: code_len = ADDR_W'(1) << LARGE_LOG2;
            default:  code_len = '0;
        endcase
    endfunction

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int FB = pair_first_bank(p);
        localparam int SB = pair_second_bank(p);
        assign len_a[p]    = code_len(bank_size[SIZE_W*FB +: SIZE_W]);
        assign len_b[p]    = code_len(bank_size[SIZE_W*SB +: SIZE_W]);
        assign pair_ilv[p] = (len_a[p] != '0) && (len_a[p] == len_b[p]);
    end

    // Pairs stack upward; empty banks add nothing to the running base.
    always_comb begin
        logic [ADDR_W-1:0] acc;
        acc = '0;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            pair_base[p] = acc;
            acc          = acc + len_a[p] + len_b[p];
        end
    end

endmodule

// File: rtl/ilv_pair_decode.sv
module ilv_pair_decode
    import ilv_map_pkg::*;
#(
    parameter int ADDR_W      = 26,
    parameter int OFF_W       = 22,
    parameter int FIRST_BANK  = 0,
    parameter int SECOND_BANK = 1
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [ADDR_W-1:0]     base,
    input  logic [ADDR_W-1:0]     len_a,
    input  logic [ADDR_W-1:0]     len_b,
    input  logic                  ilv_en,
    output logic                  hit,
    output logic [BANK_IDX_W-1:0] bank,
    output logic [OFF_W-1:0]      off,
    output logic                  ilv
);

    localparam logic [BANK_IDX_W-1:0] FB = BANK_IDX_W'(FIRST_BANK);
    localparam logic [BANK_IDX_W-1:0] SB = BANK_IDX_W'(SECOND_BANK);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] span;

    always_comb begin
        rel  = addr - base;
        span = len_a + len_b;
        hit  = (addr >= base) && (rel < span);
        ilv  = ilv_en;
        bank = FB;
        off  = '0;
        if (ilv_en) begin
            bank = rel[0] ? SB : FB;
            off  = OFF_W'(rel >> 1);
        end else if (rel < len_a) begin
            bank = FB;
            off  = OFF_W'(rel);
        end else begin
            bank = SB;
            off  = OFF_W'(rel - len_a);
        end
    end

endmodule

// File: rtl/ilv_bank_mapper.sv
module ilv_bank_mapper
    import ilv_map_pkg::*;
#(
    parameter int ADDR_W     = 26,
    parameter int SMALL_LOG2 = 20,
    parameter int LARGE_LOG2 = 22
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_strobe,
    input  logic [NUM_BANKS*SIZE_W-1:0]   bank_size,
    input  logic [ADDR_W-1:0]             addr,
    output logic                          map_hit,
    output logic [BANK_IDX_W-1:0]         map_bank,
    output logic [LARGE_LOG2-1:0]         map_off,
    output logic                          map_ilv
);

    localparam int OFF_W = LARGE_LOG2;

    typedef struct packed {
        logic [NUM_PAIRS-1:0]             ilv;
        logic [NUM_PAIRS-1:0][ADDR_W-1:0] base;
        logic [NUM_PAIRS-1:0][ADDR_W-1:0] len_a;
        logic [NUM_PAIRS-1:0][ADDR_W-1:0] len_b;
        logic                             hit;
        logic [BANK_IDX_W-1:0]            bank;
        logic [OFF_W-1:0]                 off;
        logic                             ilv_out;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_PAIRS-1:0]                  calc_ilv;
    logic [NUM_PAIRS-1:0][ADDR_W-1:0]      calc_base;
    logic [NUM_PAIRS-1:0][ADDR_W-1:0]      calc_len_a;
    logic [NUM_PAIRS-1:0][ADDR_W-1:0]      calc_len_b;

    logic [NUM_PAIRS-1:0]                  pd_hit;
    logic [NUM_PAIRS-1:0][BANK_IDX_W-1:0]  pd_bank;
    logic [NUM_PAIRS-1:0][OFF_W-1:0]       pd_off;
    logic [NUM_PAIRS-1:0]                  pd_ilv;

    ilv_cfg_calc #(
        .ADDR_W     (ADDR_W),
        .SMALL_LOG2 (SMALL_LOG2),
        .LARGE_LOG2 (LARGE_LOG2)
    ) u_cfg (
        .bank_size (bank_size),
        .pair_ilv  (calc_ilv),
        .pair_base (calc_base),
        .len_a     (calc_len_a),
        .len_b     (calc_len_b)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_dec
        ilv_pair_decode #(
            .ADDR_W      (ADDR_W),
            .OFF_W       (OFF_W),
            .FIRST_BANK  (pair_first_bank(p)),
            .SECOND_BANK (pair_second_bank(p))
        ) u_dec (
            .addr   (addr),
            .base   (st_q.base[p]),
            .len_a  (st_q.len_a[p]),
            .len_b  (st_q.len_b[p]),
            .ilv_en (st_q.ilv[p]),
            .hit    (pd_hit[p]),
            .bank   (pd_bank[p]),
            .off    (pd_off[p]),
            .ilv    (pd_ilv[p])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.hit     = 1'b0;
        st_d.bank    = '0;
        st_d.off     = '0;
        st_d.ilv_out = 1'b0;
        // Pair windows are disjoint, so at most one decoder reports a hit.
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (pd_hit[p]) begin
                st_d.hit     = 1'b1;
                st_d.bank    = pd_bank[p];
                st_d.off     = pd_off[p];
                st_d.ilv_out = pd_ilv[p];
            end
        end
        if (cfg_strobe) begin
            st_d.ilv   = calc_ilv;
            st_d.base  = calc_base;
            st_d.len_a = calc_len_a;
            st_d.len_b = calc_len_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign map_hit  = st_q.hit;
    assign map_bank = st_q.bank;
    assign map_off  = st_q.off;
    assign map_ilv  = st_q.ilv_out;

endmodule

// File: rtl/ilv_bank_mapper_chk.sv
module ilv_bank_mapper_chk
    import ilv_map_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int OFF_W  = 22
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_strobe,
    input logic [ADDR_W-1:0]     addr,
    input logic                  map_hit,
    input logic [BANK_IDX_W-1:0] map_bank,
    input logic [OFF_W-1:0]      map_off,
    input logic                  map_ilv
);

    logic [1:0] cyc_q;
    logic       seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
            if (cfg_strobe) seen_q <= 1'b1;
        end
    end

    function automatic logic is_second(input logic [BANK_IDX_W-1:0] b);
        return (b == 4'd1) || (b == 4'd4) || (b == 4'd5) || (b == 4'd8) || (b == 4'd9);
    endfunction

    AST_UNCONFIGURED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !map_hit);  // R1

    AST_MISS_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !map_hit |-> (map_bank == '0) && (map_off == '0) && !map_ilv);  // R8

    AST_ILV_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != 2'd0) && map_hit && map_ilv |-> (is_second(map_bank) == $past(addr[0])));  // R5

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3) && ($past(addr) == $past(addr, 2)) && !$past(cfg_strobe) && !$past(cfg_strobe, 2)
        |-> $stable(map_hit) && $stable(map_bank) && $stable(map_off) && $stable(map_ilv));  // R9

endmodule

bind ilv_bank_mapper ilv_bank_mapper_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (LARGE_LOG2)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_strobe (cfg_strobe),
    .addr       (addr),
    .map_hit    (map_hit),
    .map_bank   (map_bank),
    .map_off    (map_off),
    .map_ilv    (map_ilv)
);

// File: tb/ilv_bank_mapper_tb.sv
`timescale 1ns/1ps
module ilv_bank_mapper_tb;

    localparam int ADDR_W = 26;
    localparam int OFF_W  = 22;
    localparam int NV     = 14;

    // Configuration A: pair0 small/small, pair1 large/large, pair2 large only,
    // pair3 small+large, pair4 empty. Bases 0, 0x200000, 0xA00000, 0xE00000; end 0x1300000.
    localparam int VA [NV] = '{32'h0, 32'h1, 32'h1FFFFF, 32'h200000, 32'h200003, 32'h9FFFFF,
                               32'hA00000, 32'hDFFFFF, 32'hE00000, 32'hEFFFFF, 32'hF00000,
                               32'h12FFFFF, 32'h1300000, 32'h3FFFFFF};
    localparam int VH [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0, 0};
    localparam int VB [NV] = '{0, 1, 1, 2, 4, 4, 3, 3, 6, 6, 8, 8, 0, 0};
    localparam int VO [NV] = '{0, 0, 32'hFFFFF, 0, 1, 32'h3FFFFF, 0, 32'h3FFFFF, 0,
                               32'hFFFFF, 0, 32'h3FFFFF, 0, 0};
    localparam int VI [NV] = '{1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_strobe = 1'b0;
    logic [19:0]       bank_size = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic              map_hit;
    logic [3:0]        map_bank;
    logic [OFF_W-1:0]  map_off;
    logic              map_ilv;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ilv_bank_mapper u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_strobe (cfg_strobe),
        .bank_size  (bank_size),
        .addr       (addr),
        .map_hit    (map_hit),
        .map_bank   (map_bank),
        .map_off    (map_off),
        .map_ilv    (map_ilv)
    );

    function automatic logic [19:0] cfg_a();
        logic [19:0] s = '0;
        s[0 +: 2] = 2'd1;  s[2 +: 2] = 2'd1;
        s[4 +: 2] = 2'd2;  s[8 +: 2] = 2'd2;
        s[6 +: 2] = 2'd2;
        s[12 +: 2] = 2'd1; s[16 +: 2] = 2'd2;
        return s;
    endfunction

    // Configuration B: bank0 empty, bank1 small, bank2 reserved code, bank4 small.
    function automatic logic [19:0] cfg_b();
        logic [19:0] s = '0;
        s[2 +: 2] = 2'd1;
        s[4 +: 2] = 2'd3;
        s[8 +: 2] = 2'd1;
        return s;
    endfunction

    task automatic expect_out(input string tag, input int h, input int b, input int o, input int i);
        checks++;
        if (map_hit !== h[0] || map_bank !== b[3:0] || map_off !== o[OFF_W-1:0] || map_ilv !== i[0]) begin
            errors++;
            $display("FAIL %s: actual hit=%0d bank=%0d off=%0h ilv=%0d expected hit=%0d bank=%0d off=%0h ilv=%0d",
                     tag, map_hit, map_bank, map_off, map_ilv, h, b, o, i);
        end
    endtask

    task automatic apply(input int a);
        @(negedge clk);
        addr = a[ADDR_W-1:0];
        @(posedge clk);
        #1;
    endtask

    task automatic configure(input logic [19:0] s);
        @(negedge clk);
        bank_size  = s;
        cfg_strobe = 1'b1;
        @(negedge clk);
        cfg_strobe = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        bank_size = cfg_a();
        repeat (3) @(posedge clk);
        #1;
        expect_out("R1 in reset", 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(0);
        expect_out("R1 R9 no strobe yet", 0, 0, 0, 0);

        configure(cfg_a());
        for (int k = 0; k < NV; k++) begin
            apply(VA[k]);
            expect_out($sformatf("R2 R3 R4 R5 R6 R7 R8 vector %0d", k), VH[k], VB[k], VO[k], VI[k]);
        end

        // R9: new sizes without strobe are ignored
        @(negedge clk);
        bank_size = cfg_b();
        apply(32'h200003);
        expect_out("R9 sizes ignored", 1, 4, 1, 1);
        apply(32'h1300000);
        expect_out("R9 end unchanged", 0, 0, 0, 0);

        configure(cfg_b());
        apply(0);
        expect_out("R6 missing first bank", 1, 1, 0, 0);
        apply(1);
        expect_out("R4 R6 single bank linear", 1, 1, 1, 0);
        apply(32'h100000);
        expect_out("R2 R7 reserved code empty", 1, 4, 0, 0);
        apply(32'h100001);
        expect_out("R6 second bank linear", 1, 4, 1, 0);
        apply(32'h200000);
        expect_out("R8 end of config B", 0, 0, 0, 0);

        // R10: output changes only at the edge after the address is presented
        @(negedge clk);
        addr = '0;
        #1;
        expect_out("R10 before edge", 0, 0, 0, 0);
        @(posedge clk);
        #1;
        expect_out("R10 after edge", 1, 1, 0, 0);

        // R1: reset mid-run returns to all-miss
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        expect_out("R1 async reset", 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(0);
        expect_out("R1 after reset", 0, 0, 0, 0);

        finish_run();
    end

endmodule